// File: doc/BRIEF.md
# Fault isolation register bank

This block keeps the fault state of one hardware unit in a 64-bit word and presents it to software through a small register port. Each bit of the fault word stands for one error source. Hardware sets a fault bit by pulsing the matching line of `hw_fault`. Software can overwrite the fault word, clear selected bits or set selected bits. Each of these actions has its own word address, so no read-modify-write sequence is needed. A mask word is reached the same way and hides the bits that firmware has chosen to ignore.

Two action words together give every fault bit a two-bit severity code. From the live (unmasked) faults the block derives three level outputs:
- a summary flag that is high when any unmasked fault is present;
- a checkstop flag;
- an attention flag.

A first-error word records which bit fired first after it was last cleared. A write to that word clears it, whatever the data. Error-report and status addresses accept writes and ignore them.

The register port uses word indices, so byte address bits [2:0] are dropped upstream. Every access is one full 64-bit word. Reads are combinational from the registers. Writes take effect at the rising clock edge.

Top module: `fir_bank`

## Requirements
- R1: After a synchronous active-low reset, every register is zero. Every index reads zero and all three flag outputs are low.
- R2: A write to index 0 replaces the fault word with the write data.
- R3: A write to index 1 ANDs the fault word with the write data, so only bits written as 0 are cleared.
- R4: A write to index 2 ORs the write data into the fault word.
- R5: The mask word takes a direct write at index 3, an AND at index 4 and an OR at index 5.
- R6: Action word 0 (index 6) and action word 1 (index 7) are plain 64-bit read/write registers.
- R7: A `hw_fault` bit that is high at a rising edge sets that fault bit at that edge. It wins over a software clear or overwrite of the same bit in the same cycle.
- R8: The first-error word at index 8 is one-hot or zero. While it is zero, it captures the lowest-numbered fault bit that goes from 0 to 1 at an edge. While it is nonzero, it holds its value.
- R9: Any write to index 8 forces the first-error word to zero at that edge, whatever the data. This takes priority over a capture in the same cycle.
- R10: Writes to the error-report indices 9 and 10, the status index 11 and the unused indices 12 to 15 change no register. These indices read zero.
- R11: `fault_live` is the OR over all bits of (fault AND NOT mask).
- R12: For each live bit, the code {action0, action1} selects the flag: 00 is recoverable and drives no extra flag; 01 drives `fault_checkstop`; 10 and 11 drive `fault_attn`.
- R13: Reading an alias index (1, 2, 4 or 5) returns the current value of its underlying register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_idx | input | 4 | Word index of the access |
| wr_en | input | 1 | Write strobe; the write commits at the rising edge |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `reg_idx`, combinational |
| hw_fault | input | DATA_W | Hardware fault set lines, one per fault bit |
| fault_live | output | 1 | Any unmasked fault present |
| fault_checkstop | output | 1 | Any unmasked fault coded 01 |
| fault_attn | output | 1 | Any unmasked fault coded 10 or 11 |

## Verification
The AND-alias and ignored-write properties only make a claim in cycles where `hw_fault` is all zero. Outside those cycles a hardware set may legally change the fault word, so the properties check nothing there. The stimulus makes `hw_fault` sparse and leaves it zero on most writes, so these properties are exercised often. The properties also take `reg_idx` and `wr_data` to be settled before each rising edge. The bench drives all inputs on the falling edge and returns `wr_en` and `hw_fault` to zero before it reads back.

// File: rtl/fir_pkg.sv
// Package: shared word indices and severity codes for the fault
// isolation register bank.
// Assumes: word-indexed access; byte address bits [2:0] are stripped upstream.
package fir_pkg;

    localparam int IDX_W = 4;

    typedef enum logic [IDX_W-1:0] {
        IDX_FAULT     = 4'd0,
        IDX_FAULT_AND = 4'd1,
        IDX_FAULT_OR  = 4'd2,
        IDX_MASK      = 4'd3,
        IDX_MASK_AND  = 4'd4,
        IDX_MASK_OR   = 4'd5,
        IDX_ACT0      = 4'd6,
        IDX_ACT1      = 4'd7,
        IDX_FIRST     = 4'd8,
        IDX_ERR_A     = 4'd9,
        IDX_ERR_B     = 4'd10,
        IDX_STATUS    = 4'd11
    } fir_idx_e;

    // Severity codes formed as {action0 bit, action1 bit}.
    typedef enum logic [1:0] {
        SEV_RECOV  = 2'b00,
        SEV_CHKSTP = 2'b01,
        SEV_ATTN_A = 2'b10,
        SEV_ATTN_B = 2'b11
    } fir_sev_e;

endpackage

// File: rtl/fir_word_reg.sv
// Module: fir_word_reg
// Holds one register word that can be replaced, AND-ed or OR-ed by
// software, with hardware set lines OR-ed in last.
// Assumes: at most one of the three write strobes is high per cycle.
// Exposes the next-state value so that a neighbour can detect rising bits.
module fir_word_reg #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_put,
    input  logic         wr_and,
    input  logic         wr_or,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q,
    output logic [W-1:0] d
);

    logic [W-1:0] sw_val;

    // Pick the software result, then let hardware set lines win.
    always_comb begin
        sw_val = q;
        if (wr_put)
            sw_val = wdata;
        else if (wr_and)
            sw_val = q & wdata;
        else if (wr_or)
            sw_val = q | wdata;
        d = sw_val | hw_set;
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

endmodule

// File: rtl/fir_first_capture.sv
// Module: fir_first_capture
// Records, as a one-hot word, the lowest fault bit that rises while
// the record is empty. A clear strobe empties it and beats a capture.
// Assumes: cur/nxt are the fault word's present and next-state values.
module fir_first_capture #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] q
);

    logic [W-1:0] rise;
    logic [W-1:0] lowest;

    // Isolate the lowest rising bit (two's complement trick).
    always_comb begin
        rise   = nxt & ~cur;
        lowest = rise & (~rise + {{(W-1){1'b0}}, 1'b1});
    end

    // Clear wins; capture only while empty; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (q == '0)
            q <= lowest;
    end

endmodule

// File: rtl/fir_flag_reduce.sv
// Module: fir_flag_reduce
// Reduces the live faults to three flags: any live fault, any live
// fault coded checkstop, and any live fault coded attention.
// Assumes: purely combinational; the inputs are register outputs.
module fir_flag_reduce #(
    parameter int W = 64
) (
    input  logic [W-1:0] fault,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] act0,
    input  logic [W-1:0] act1,
    output logic         any_live,
    output logic         any_chk,
    output logic         any_attn
);

    logic [W-1:0] chk_bits;
    logic [W-1:0] attn_bits;
    logic [W-1:0] live;

    // Classify each bit by its two-bit severity code.
    for (genvar b = 0; b < W; b++) begin : g_bit
        fir_pkg::fir_sev_e sev;
        assign sev          = fir_pkg::fir_sev_e'({act0[b], act1[b]});
        assign live[b]      = fault[b] & ~mask[b];
        assign chk_bits[b]  = live[b] & (sev == fir_pkg::SEV_CHKSTP);
        assign attn_bits[b] = live[b] & ((sev == fir_pkg::SEV_ATTN_A) |
                                         (sev == fir_pkg::SEV_ATTN_B));
    end

    // OR-reduce each class to its flag.
    always_comb begin
        any_live = |live;
        any_chk  = |chk_bits;
        any_attn = |attn_bits;
    end

endmodule

// File: rtl/fir_bank.sv
// Module: fir_bank (top)
// Fault isolation register bank: fault, mask, two action words and a
// first-error word behind a word-indexed register port.
// Assumes: one 64-bit access per cycle; reads are combinational;
// synchronous active-low reset.
module fir_bank
    import fir_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] hw_fault,
    output logic              fault_live,
    output logic              fault_checkstop,
    output logic              fault_attn
);

    localparam logic [DATA_W-1:0] ZERO_W = '0;

    logic f_put, f_and, f_or;
    logic m_put, m_and, m_or;
    logic a0_put, a1_put, first_clr;

    logic [DATA_W-1:0] fault_q, fault_d;
    logic [DATA_W-1:0] mask_q, mask_d;
    logic [DATA_W-1:0] act0_q, act0_d;
    logic [DATA_W-1:0] act1_q, act1_d;
    logic [DATA_W-1:0] first_q;

    // Decode the write strobe into one action per register.
    always_comb begin
        f_put = 1'b0; f_and = 1'b0; f_or = 1'b0;
        m_put = 1'b0; m_and = 1'b0; m_or = 1'b0;
        a0_put = 1'b0; a1_put = 1'b0; first_clr = 1'b0;
        if (wr_en) begin
            case (reg_idx)
                IDX_FAULT:     f_put = 1'b1;
                IDX_FAULT_AND: f_and = 1'b1;
                IDX_FAULT_OR:  f_or  = 1'b1;
                IDX_MASK:      m_put = 1'b1;
                IDX_MASK_AND:  m_and = 1'b1;
                IDX_MASK_OR:   m_or  = 1'b1;
                IDX_ACT0:      a0_put = 1'b1;
                IDX_ACT1:      a1_put = 1'b1;
                IDX_FIRST:     first_clr = 1'b1;
                default: ;
            endcase
        end
    end

    fir_word_reg #(.W(DATA_W)) u_fault (
        .clk(clk), .rst_n(rst_n),
        .wr_put(f_put), .wr_and(f_and), .wr_or(f_or),
        .wdata(wr_data), .hw_set(hw_fault),
        .q(fault_q), .d(fault_d)
    );

    fir_word_reg #(.W(DATA_W)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .wr_put(m_put), .wr_and(m_and), .wr_or(m_or),
        .wdata(wr_data), .hw_set(ZERO_W),
        .q(mask_q), .d(mask_d)
    );

    fir_word_reg #(.W(DATA_W)) u_act0 (
        .clk(clk), .rst_n(rst_n),
        .wr_put(a0_put), .wr_and(1'b0), .wr_or(1'b0),
        .wdata(wr_data), .hw_set(ZERO_W),
        .q(act0_q), .d(act0_d)
    );

    fir_word_reg #(.W(DATA_W)) u_act1 (
        .clk(clk), .rst_n(rst_n),
        .wr_put(a1_put), .wr_and(1'b0), .wr_or(1'b0),
        .wdata(wr_data), .hw_set(ZERO_W),
        .q(act1_q), .d(act1_d)
    );

    fir_first_capture #(.W(DATA_W)) u_first (
        .clk(clk), .rst_n(rst_n),
        .clr(first_clr), .cur(fault_q), .nxt(fault_d),
        .q(first_q)
    );

    fir_flag_reduce #(.W(DATA_W)) u_flags (
        .fault(fault_q), .mask(mask_q), .act0(act0_q), .act1(act1_q),
        .any_live(fault_live), .any_chk(fault_checkstop), .any_attn(fault_attn)
    );

    // Read mux: aliases return their base word; the rest read zero.
    always_comb begin
        case (reg_idx)
            IDX_FAULT, IDX_FAULT_AND, IDX_FAULT_OR: rd_data = fault_q;
            IDX_MASK, IDX_MASK_AND, IDX_MASK_OR:    rd_data = mask_q;
            IDX_ACT0:  rd_data = act0_q;
            IDX_ACT1:  rd_data = act1_q;
            IDX_FIRST: rd_data = first_q;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/fir_bank_chk.sv
// Module: fir_bank_chk
// Concurrent checks on the fault bank, bound to fir_bank.
// Assumes: inputs settle before each rising edge.
module fir_bank_chk
    import fir_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  reg_idx,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] hw_fault,
    input logic [DATA_W-1:0] fault_q,
    input logic [DATA_W-1:0] mask_q,
    input logic [DATA_W-1:0] act0_q,
    input logic [DATA_W-1:0] act1_q,
    input logic [DATA_W-1:0] first_q
);

    localparam logic [DATA_W-1:0] ZERO_W = '0;

    AST_HW_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_fault != ZERO_W) |=> ((fault_q & $past(hw_fault)) == $past(hw_fault))); // R7

    AST_FAULT_AND_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == IDX_FAULT_AND && hw_fault == ZERO_W)
        |=> (fault_q == ($past(fault_q) & $past(wr_data)))); // R3

    AST_FIRST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(first_q)); // R8

    AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (first_q != ZERO_W && !(wr_en && reg_idx == IDX_FIRST))
        |=> $stable(first_q)); // R8

    AST_FIRST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == IDX_FIRST) |=> (first_q == ZERO_W)); // R9

    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx >= IDX_ERR_A && hw_fault == ZERO_W)
        |=> ($stable(fault_q) && $stable(mask_q) && $stable(act0_q) &&
             $stable(act1_q) && $stable(first_q))); // R10

endmodule

bind fir_bank fir_bank_chk #(.DATA_W(DATA_W)) u_fir_bank_chk (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
    .wr_data(wr_data), .hw_fault(hw_fault),
    .fault_q(fault_q), .mask_q(mask_q), .act0_q(act0_q),
    .act1_q(act1_q), .first_q(first_q)
);

// File: tb/test_fir_bank.sv
`timescale 1ns/1ps
module test_fir_bank;

    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   reg_idx = '0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic [W-1:0] hw_fault = '0;
    logic         fault_live, fault_checkstop, fault_attn;

    int total = 0;
    int bad = 0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    // expected state, from the requirements
    logic [W-1:0] e_fault = '0, e_mask = '0, e_a0 = '0, e_a1 = '0, e_first = '0;

    always #4 clk = ~clk;

    fir_bank #(.DATA_W(W)) i_fir_bank (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .hw_fault(hw_fault),
        .fault_live(fault_live), .fault_checkstop(fault_checkstop),
        .fault_attn(fault_attn)
    );

    function automatic logic [63:0] nxt_rand(input logic [63:0] s);
        logic [63:0] x = s;
        x ^= x << 13; x ^= x >> 7; x ^= x << 17;
        return x;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_read(input int a);
        case (a)
            0, 1, 2: return e_fault;
            3, 4, 5: return e_mask;
            6: return e_a0;
            7: return e_a1;
            8: return e_first;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R2";  1: return "R3 R13"; 2: return "R4 R13";
            3: return "R5";  4: return "R5 R13"; 5: return "R5 R13";
            6, 7: return "R6"; 8: return "R8";
            default: return "R10";
        endcase
    endfunction

    // Update the expected state for one write cycle (R2..R10).
    task automatic model(input int a, input logic [W-1:0] d, input logic [W-1:0] hw);
        logic [W-1:0] nf, rise;
        nf = e_fault;
        if (a == 0) nf = d;
        else if (a == 1) nf = e_fault & d;
        else if (a == 2) nf = e_fault | d;
        nf |= hw;
        rise = nf & ~e_fault;
        if (a == 8) e_first = '0;
        else if (e_first == '0) e_first = rise & (~rise + 1);
        e_fault = nf;
        if (a == 3) e_mask = d;
        else if (a == 4) e_mask &= d;
        else if (a == 5) e_mask |= d;
        if (a == 6) e_a0 = d;
        if (a == 7) e_a1 = d;
    endtask

    task automatic op(input int a, input logic [W-1:0] d, input logic [W-1:0] hw);
        @(negedge clk);
        reg_idx = 4'(a); wr_data = d; wr_en = 1'b1; hw_fault = hw;
        @(posedge clk);
        model(a, d, hw);
        @(negedge clk);
        wr_en = 1'b0; hw_fault = '0;
    endtask

    // Read every index and the flags; call in the low clock phase.
    task automatic verify_all();
        logic [W-1:0] live;
        for (int a = 0; a < 16; a++) begin
            reg_idx = 4'(a);
            #0.2;
            check(tag_of(a), rd_data, exp_read(a));
        end
        live = e_fault & ~e_mask;
        check("R11", W'(fault_live), W'(|live));
        check("R12 checkstop", W'(fault_checkstop), W'(|(live & ~e_a0 & e_a1)));
        check("R12 attn", W'(fault_attn), W'(|(live & e_a0)));
    endtask

    initial begin
        #(8.0 * 150000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] d, hw;
        int a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 16; i++) begin
            reg_idx = 4'(i); #0.2;
            check("R1 reset read", rd_data, '0);
        end
        check("R1 reset flags", W'({fault_live, fault_checkstop, fault_attn}), '0);

        // Broad sweep: every index, mixed data and sparse hardware sets.
        for (int n = 0; n < 480; n++) begin
            seed = nxt_rand(seed); d = seed;
            seed = nxt_rand(seed); a = int'(seed[3:0]);
            seed = nxt_rand(seed); hw = (n % 4 == 0) ? (seed & nxt_rand(seed) & (seed << 7)) : '0;
            op(a, d, hw);
            verify_all();
        end

        // R7: hardware set beats a software clear of the same bit.
        op(0, '1, '0);
        op(1, '0, W'(64'h20));
        reg_idx = 4'd0; #0.2;
        check("R7 set wins over clear", rd_data, W'(64'h20));
        op(0, '0, W'(64'h100));
        reg_idx = 4'd0; #0.2;
        check("R7 set wins over overwrite", rd_data, W'(64'h100));

        // R8 / R9: first-error capture per bit.
        for (int i = 0; i < W; i++) begin
            op(0, '0, '0);
            op(8, '1, '0);
            reg_idx = 4'd8; #0.2;
            check("R9 write clears first", rd_data, '0);
            op(2, ({W{1'b1}} << i), '0);
            reg_idx = 4'd8; #0.2;
            check("R8 lowest rising bit", rd_data, W'(1) << i);
            if (i > 0) begin
                op(2, W'(1), '0);
                reg_idx = 4'd8; #0.2;
                check("R8 holds when nonzero", rd_data, W'(1) << i);
            end
        end
        // R9: clear wins over capture in the same cycle.
        op(0, '0, '0);
        op(8, '0, W'(64'h8));
        reg_idx = 4'd8; #0.2;
        check("R9 clear beats capture", rd_data, '0);

        // R12: each severity code on each of a few bits.
        op(3, '0, '0);
        for (int b = 0; b < W; b += 9) begin
            for (int c = 0; c < 4; c++) begin
                op(0, W'(1) << b, '0);
                op(6, c[1] ? (W'(1) << b) : '0, '0);
                op(7, c[0] ? (W'(1) << b) : '0, '0);
                check("R12 checkstop code", W'(fault_checkstop), W'(c == 1));
                check("R12 attn code", W'(fault_attn), W'(c >= 2));
                check("R11 live", W'(fault_live), W'(1));
                verify_all();
            end
        end
        // R11: mask hides the bit.
        op(5, '1, '0);
        check("R11 masked", W'(fault_live), '0);
        verify_all();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule